// File: doc/BRIEF.md
# Narrow-Bus Memory Access Sequencer

This block sits between a CPU core that issues byte and 16-bit word loads and stores and a memory system whose data path is only eight bits wide. The core presents a request (address, size, direction, write data) and holds it until a one-cycle ready pulse comes back with the read data. The sequencer breaks each word into two byte transfers, lowest address first. It drives the byte-wide memory port for each transfer and packs the returned bytes into a little-endian result.

Access time depends on where each byte lands in the 20-bit address space. Bytes in the special-function-register window (0x00000 to 0x002FF) hold the memory port for four cycles. Bytes in the RAM/ROM window (0x00400 upward) take one cycle. The gap between the two windows is unimplemented: such a byte still takes one cycle, but the memory port is not enabled and the byte reads as zero. The region is decided separately for every byte, so a word that crosses a window edge mixes the two timings. Addresses wrap modulo 2^20.

Top module: `nbus_seq`

## Requirements
- R1: A byte access to the RAM/ROM window (0x00400..0xFFFFF) drives the memory port (mem_en high, address stable) for exactly one cycle. req_ready rises in the cycle right after that transfer cycle.
- R2: A word access at address A makes two transfers: the byte at A first, then the byte at A+1 (modulo 2^20). No address alignment is required. Two RAM/ROM bytes take two consecutive transfer cycles.
- R3: Every byte in the register window (0x00000..0x002FF) keeps mem_en high and mem_addr stable for exactly four consecutive cycles, so a word there takes eight transfer cycles.
- R4: Read data is little-endian. For a word, req_rdata = {byte at A+1, byte at A}. For a byte, req_rdata = {8'h00, byte at A}.
- R5: On a write, mem_we is high with mem_en. mem_wdata carries req_wdata[7:0] for the byte at A and req_wdata[15:8] for the byte at A+1. Reads keep mem_we low.
- R6: A byte in the unimplemented gap (0x00300..0x003FF) takes one cycle with mem_en and mem_we low. It contributes 0x00 to the read data, whatever mem_rdata carries.
- R7: Timing and region are decided per byte. A word at 0x002FF takes four cycles, then one. A word at 0xFFFFF takes one cycle, then wraps to 0x00000 for four.
- R8: req_ready is high for exactly one cycle per request, and mem_en is low in that cycle. A request presented in the cycle after the ready pulse is accepted at the end of that cycle.
- R9: After reset, req_ready, mem_en and mem_we are low and req_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address of the access (low byte for a word) |
| req_wdata | input | 16 | Store data; bits 7:0 go to the lower address |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Load result, valid with req_ready |
| mem_en | output | 1 | Byte transfer active on the memory port |
| mem_we | output | 1 | Byte transfer is a write |
| mem_addr | output | 20 | Byte address of the current transfer |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte returned by memory, sampled in the last transfer cycle |

## Verification
Byte and word loads and stores are sent to each window on its own. Comparing their transfer counts separates the one-cycle RAM/ROM timing from the four-cycle register timing. A word at an odd address checks the byte order and shows that no alignment is required. Words that cross 0x002FF/0x00300 and wrap from 0xFFFFF expose any design that decides timing once per request instead of per byte. Reads from the unimplemented gap, where the memory model returns nonzero data, show whether those bytes are really forced to zero.

// File: rtl/nbus_pkg.sv
package nbus_pkg;

    // Address window a byte falls into
    typedef enum logic [1:0] {
        RGN_SFR  = 2'd0,
        RGN_MEM  = 2'd1,
        RGN_NONE = 2'd2
    } rgn_e;

    // Sequencer phase
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } st_e;

endpackage

// File: rtl/nbus_region_dec.sv
module nbus_region_dec
    import nbus_pkg::*;
#(
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] SFR_LAST  = 20'h002FF,
    parameter logic [ADDR_W-1:0] MEM_FIRST = 20'h00400,
    parameter logic [ADDR_W-1:0] MEM_LAST  = 20'hFFFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rgn
);

    always_comb begin
        if (addr <= SFR_LAST) begin
            rgn = RGN_SFR;
        end else if ((addr >= MEM_FIRST) && (addr <= MEM_LAST)) begin
            rgn = RGN_MEM;
        end else begin
            rgn = RGN_NONE;
        end
    end

endmodule

// File: rtl/nbus_wait_timer.sv
module nbus_wait_timer #(
    parameter int MAX_WAIT = 4,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CNT_W'(1));

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CNT_W'(MAX_WAIT))); // R3

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/nbus_byte_lane.sv
module nbus_byte_lane #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 1
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] acc,
    input  logic [7:0]        rbyte,
    output logic [7:0]        wbyte,
    output logic [DATA_W-1:0] acc_nx
);

    localparam int LANES = DATA_W / 8;

    always_comb begin
        wbyte  = '0;
        acc_nx = acc;
        for (int i = 0; i < LANES; i++) begin
            if (idx == IDX_W'(i)) begin
                wbyte            = wdata[i*8 +: 8];
                acc_nx[i*8 +: 8] = rbyte;
            end
        end
    end

endmodule

// File: rtl/nbus_seq.sv
module nbus_seq
    import nbus_pkg::*;
#(
    parameter int                ADDR_W    = 20,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] SFR_LAST  = 20'h002FF,
    parameter logic [ADDR_W-1:0] MEM_FIRST = 20'h00400,
    parameter logic [ADDR_W-1:0] MEM_LAST  = 20'hFFFFF,
    parameter int                SFR_WAIT  = 4,
    parameter int                MEM_WAIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    localparam int LANES     = DATA_W / 8;
    localparam int IDX_W     = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int MAX_WAIT  = (SFR_WAIT > MEM_WAIT) ? SFR_WAIT : MEM_WAIT;
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);
    localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(LANES - 1);

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              wd;
        logic [DATA_W-1:0] wdata;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] acc;
    } seq_t;

    seq_t s_d;
    seq_t s_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] nxt_addr;
    rgn_e              cur_rgn;
    rgn_e              nxt_rgn;
    logic [CNT_W-1:0]  nxt_wait;
    logic              accept;
    logic              more;
    logic              beat_end;
    logic              tmr_load;
    logic              tmr_last;
    logic [7:0]        rbyte;
    logic [7:0]        wbyte;
    logic [DATA_W-1:0] acc_nx;

    // Byte currently on the memory port and the byte whose wait gets loaded next
    assign cur_addr = s_q.addr + ADDR_W'(s_q.idx);
    assign nxt_addr = (s_q.st == ST_IDLE) ? req_addr : (cur_addr + ADDR_W'(1));

    nbus_region_dec #(
        .ADDR_W    (ADDR_W),
        .SFR_LAST  (SFR_LAST),
        .MEM_FIRST (MEM_FIRST),
        .MEM_LAST  (MEM_LAST)
    ) u_dec_cur (
        .addr (cur_addr),
        .rgn  (cur_rgn)
    );

    nbus_region_dec #(
        .ADDR_W    (ADDR_W),
        .SFR_LAST  (SFR_LAST),
        .MEM_FIRST (MEM_FIRST),
        .MEM_LAST  (MEM_LAST)
    ) u_dec_nxt (
        .addr (nxt_addr),
        .rgn  (nxt_rgn)
    );

    assign nxt_wait = (nxt_rgn == RGN_SFR) ? CNT_W'(SFR_WAIT) : CNT_W'(MEM_WAIT);

    assign accept   = (s_q.st == ST_IDLE) && req_valid;
    assign more     = s_q.wd && (s_q.idx != LAST_LANE);
    assign beat_end = (s_q.st == ST_XFER) && tmr_last;
    assign tmr_load = accept || (beat_end && more);

    nbus_wait_timer #(
        .MAX_WAIT (MAX_WAIT),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (nxt_wait),
        .last     (tmr_last)
    );

    // Unimplemented bytes read as zero regardless of the memory bus
    assign rbyte = (cur_rgn == RGN_NONE) ? 8'h00 : mem_rdata;

    nbus_byte_lane #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_lane (
        .idx    (s_q.idx),
        .wdata  (s_q.wdata),
        .acc    (s_q.acc),
        .rbyte  (rbyte),
        .wbyte  (wbyte),
        .acc_nx (acc_nx)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st    = ST_XFER;
                    s_d.addr  = req_addr;
                    s_d.wr    = req_write;
                    s_d.wd    = req_word;
                    s_d.wdata = req_wdata;
                    s_d.idx   = '0;
                    s_d.acc   = '0;
                end
            end
            ST_XFER: begin
                if (tmr_last) begin
                    s_d.acc = acc_nx;
                    if (more) begin
                        s_d.idx = s_q.idx + 1'b1;
                    end else begin
                        s_d.st = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.st == ST_DONE);
    assign req_rdata = s_q.acc;
    assign mem_en    = (s_q.st == ST_XFER) && (cur_rgn != RGN_NONE);
    assign mem_we    = mem_en && s_q.wr;
    assign mem_addr  = (s_q.st == ST_XFER) ? cur_addr : '0;
    assign mem_wdata = mem_we ? wbyte : 8'h00;

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R8

    AST_READY_QUIET_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_en && !mem_we)); // R8

    AST_READY_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> $past(s_q.st == ST_XFER)); // R8

    AST_SFR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && (mem_addr <= SFR_LAST) && !tmr_last)
            |=> (mem_en && $stable(mem_addr) && $stable(mem_we))); // R3

    AST_MEM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && (mem_addr >= MEM_FIRST) && (mem_addr <= MEM_LAST))
            |=> !(mem_en && $stable(mem_addr))); // R1

    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> ((mem_addr <= SFR_LAST) || (mem_addr >= MEM_FIRST))); // R6

endmodule

// File: tb/sim_nbus_seq.sv
module sim_nbus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic [15:0] req_rdata;
    logic        mem_en;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    nbus_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_word  (req_word),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .req_rdata (req_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Memory model: contents written by the design, else a fixed pattern
    logic [7:0] model_mem [int];
    // Bench's own record of what it stored, used for expected read data
    logic [7:0] shadow [int];

    function automatic logic [7:0] pattern(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'hA5;
    endfunction

    function automatic logic [7:0] model_peek(input logic [19:0] a);
        if (model_mem.exists(int'(a))) return model_mem[int'(a)];
        return pattern(a);
    endfunction

    function automatic bit in_impl(input logic [19:0] a);
        return (a <= 20'h002FF) || (a >= 20'h00400);
    endfunction

    function automatic int byte_wait(input logic [19:0] a);
        return (a <= 20'h002FF) ? 4 : 1;
    endfunction

    function automatic logic [7:0] expect_byte(input logic [19:0] a);
        if (!in_impl(a)) return 8'h00;
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return pattern(a);
    endfunction

    always @(negedge clk) mem_rdata <= model_peek(mem_addr);
    always @(posedge clk) if (mem_en && mem_we) model_mem[int'(mem_addr)] = mem_wdata;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Transfer log of one request, one entry per cycle before ready
    logic [19:0] log_addr [32];
    logic        log_en   [32];
    logic        log_we   [32];
    logic [7:0]  log_wd   [32];

    task automatic do_access(input logic wr, input logic wd, input logic [19:0] a,
                             input logic [15:0] wdat, input string req);
        int n;
        bit got;
        int total;
        int e;
        int bad;
        int nb;
        logic [15:0] exp_rd;
        @(negedge clk);
        chk("R8", "ready low before request", {31'b0, req_ready}, 32'd0);
        req_valid = 1'b1;
        req_write = wr;
        req_word  = wd;
        req_addr  = a;
        req_wdata = wdat;
        n = 0;
        got = 1'b0;
        while (!got && n < 32) begin
            @(negedge clk);
            if (req_ready) begin
                got = 1'b1;
            end else begin
                log_addr[n] = mem_addr;
                log_en[n]   = mem_en;
                log_we[n]   = mem_we;
                log_wd[n]   = mem_wdata;
                n++;
            end
        end
        req_valid = 1'b0;
        chk(req, "ready seen", {31'b0, got}, 32'd1);
        chk("R8", "mem_en low in ready cycle", {31'b0, mem_en}, 32'd0);
        nb = wd ? 2 : 1;
        total = 0;
        for (int b = 0; b < nb; b++) total += byte_wait(a + 20'(b));
        chk(req, "transfer cycles", n, total);
        e = 0;
        bad = 0;
        for (int b = 0; b < nb; b++) begin
            logic [19:0] ba;
            ba = a + 20'(b);
            for (int c = 0; c < byte_wait(ba); c++) begin
                if (e < n) begin
                    if (log_addr[e] !== ba) bad++;
                    if (log_en[e] !== in_impl(ba)) bad++;
                    if (log_we[e] !== (wr && in_impl(ba))) bad++;
                    if (wr && in_impl(ba) && log_wd[e] !== wdat[b*8 +: 8]) bad++;
                end
                e++;
            end
        end
        chk(req, "port sequence mismatches", bad, 0);
        if (wr) begin
            for (int b = 0; b < nb; b++) begin
                logic [19:0] ba;
                ba = a + 20'(b);
                if (in_impl(ba)) shadow[int'(ba)] = wdat[b*8 +: 8];
            end
        end else begin
            exp_rd = {wd ? expect_byte(a + 20'd1) : 8'h00, expect_byte(a)};
            chk(req, "read data", {16'b0, req_rdata}, {16'b0, exp_rd});
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9", "ready after reset", {31'b0, req_ready}, 32'd0);
        chk("R9", "mem_en after reset", {31'b0, mem_en}, 32'd0);
        chk("R9", "mem_we after reset", {31'b0, mem_we}, 32'd0);
        chk("R9", "rdata after reset", {16'b0, req_rdata}, 32'd0);
    endtask

    task automatic t_byte_mem;
        do_access(1'b0, 1'b0, 20'h01234, 16'h0000, "R1");
        do_access(1'b1, 1'b0, 20'h01235, 16'hEE3C, "R5");
        do_access(1'b0, 1'b0, 20'h01235, 16'h0000, "R4");
    endtask

    task automatic t_word_mem;
        do_access(1'b1, 1'b1, 20'h02000, 16'hBEEF, "R5");
        do_access(1'b0, 1'b1, 20'h02000, 16'h0000, "R2");
        do_access(1'b0, 1'b0, 20'h02001, 16'h0000, "R4");
        do_access(1'b0, 1'b1, 20'h04567, 16'h0000, "R2");
    endtask

    task automatic t_sfr;
        do_access(1'b0, 1'b0, 20'h00010, 16'h0000, "R3");
        do_access(1'b1, 1'b1, 20'h00100, 16'h1234, "R3");
        do_access(1'b0, 1'b1, 20'h00100, 16'h0000, "R3");
    endtask

    task automatic t_gap;
        do_access(1'b0, 1'b1, 20'h00380, 16'h0000, "R6");
        do_access(1'b1, 1'b0, 20'h003FF, 16'h00AA, "R6");
        chk("R6", "gap write left memory untouched",
            {31'b0, model_mem.exists(int'(20'h003FF))}, 32'd0);
    endtask

    task automatic t_straddle;
        do_access(1'b0, 1'b1, 20'h002FF, 16'h0000, "R7");
        do_access(1'b0, 1'b1, 20'hFFFFF, 16'h0000, "R7");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_byte_mem();
        t_word_mem();
        t_sfr();
        t_gap();
        t_straddle();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule